// File: doc/BRIEF.md
# Edge-Steered Configuration Pin Decoder

This block lets one configuration pin set two internal control bits. Which bit the pin writes depends on the active-low sync input. A fixed number of clocks after each edge on sync, the block samples the pin. A falling sync edge sends the sample to the sync-insertion bit (`ins3_int`), which selects sync on all channels or on the luminance channel only. A rising sync edge sends the sample to the format bit (`m2_int`). A second pin, `m1`, is not registered. It joins the format bit to form a four-way operating mode, and a change on `m1` shows in the mode in the same cycle.

A board can tie the shared pin high or low, so that both bits take the same value. It can also drive the pin from the sync line through a two-clock delay, with or without inversion, so that the two bits take opposite values. The format bit is only defined once a rising-edge sample has been taken, and `m2_int_valid` reports this.

Top module: `mode_pin_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, `m2_int`, `ins3_int` and `m2_int_valid` are all cleared to 0 after that edge.
- R2: After a high-to-low transition of `sync_n`, the value of `m2` at the second rising clock edge after the transition is loaded into `ins3_int` at that edge, and `m2_int` does not change.
- R3: After a low-to-high transition of `sync_n`, the value of `m2` at the second rising clock edge after the transition is loaded into `m2_int` at that edge, and `ins3_int` does not change.
- R4: `m2_int_valid` stays 0 after reset until the first capture that follows a rising `sync_n` edge. Captures after falling edges do not set it.
- R5: The value of `m2` at every other clock edge has no effect, including the first edge after a `sync_n` transition.
- R6: When `sync_n` changes again before a pending capture has been taken, that capture is dropped. The delay restarts, and the target is set by the direction of the newer edge.
- R7: `mode` is `{m1, m2_int}` and follows `m1` in the same cycle, with no register. The encodings are: 2'b00 RGB 4:4:4, 2'b01 YCbCr 4:4:4, 2'b10 YCbCr 4:2:2 on two ports, 2'b11 YCbCr 4:2:2 on one port.
- R8: When `m2` is driven with `sync_n` delayed by two clocks, the result is `m2_int`=0 and `ins3_int`=1. When it is driven with inverted `sync_n` delayed by two clocks, the result is `m2_int`=1 and `ins3_int`=0.
- R9: Once `m2_int_valid` is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Sync control, active low; its edges steer the capture |
| m1 | input | 1 | Static mode pin, used without a register |
| m2 | input | 1 | Shared configuration pin |
| m2_int | output | 1 | Format bit, loaded after rising sync edges |
| ins3_int | output | 1 | Sync-insertion bit, loaded after falling sync edges |
| m2_int_valid | output | 1 | Set once `m2_int` has been loaded |
| mode | output | 2 | Operating mode `{m1, m2_int}` |

## Verification
The hardest case to reach is a second sync edge that lands exactly on the edge where the first capture was due. The stimulus toggles `sync_n` on two consecutive negative clock edges and changes `m2` in between. A check then confirms that only the later edge's target changed. Sampling only at the second edge is tested by holding the opposite value on `m2` on both neighbouring edges. The delayed-sync wiring is reproduced in the bench with a two-entry history of `sync_n`.

// File: rtl/mpl_pkg.sv
package mpl_pkg;
  typedef enum logic [1:0] {
    MODE_RGB444     = 2'b00,
    MODE_YCC444     = 2'b01,
    MODE_YCC422_2P  = 2'b10,
    MODE_YCC422_1P  = 2'b11
  } mode_e;

  localparam logic SYNC_IDLE = 1'b1;
endpackage

// File: rtl/mpl_edge_det.sv
module mpl_edge_det
  import mpl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  output logic edge_any,
  output logic edge_rise
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= SYNC_IDLE;
    else     sync_q <= sync_n;
  end

  assign edge_any  = sync_n ^ sync_q;
  assign edge_rise = sync_n & ~sync_q;

  // a detected rise must leave the registered copy high next cycle
  p_rise_seen_r3: assert property (@(posedge clk) disable iff (rst)
    edge_rise |=> sync_q);
endmodule

// File: rtl/mpl_cap_timer.sv
module mpl_cap_timer #(
  parameter int CAPTURE_EDGE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_any,
  input  logic edge_rise,
  output logic cap,
  output logic cap_rise
);
  localparam int CW = $clog2(CAPTURE_EDGE + 1);
  localparam logic [CW-1:0] LOAD = CW'(CAPTURE_EDGE - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic          dir_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_rise <= 1'b0;
    end else if (edge_any) begin
      cnt      <= LOAD;
      dir_rise <= edge_rise;
    end else if (cnt != '0) begin
      cnt      <= cnt - ONE;
    end
  end

  assign cap      = (cnt == ONE) && !edge_any;
  assign cap_rise = dir_rise;

  // every edge restarts the delay, discarding any pending capture
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    edge_any |=> (cnt == LOAD));
  p_dir_kept_r6: assert property (@(posedge clk) disable iff (rst)
    !edge_any |=> $stable(dir_rise));
endmodule

// File: rtl/mpl_cfg_regs.sv
module mpl_cfg_regs (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  input  logic cap_rise,
  input  logic m2,
  output logic m2_int,
  output logic ins3_int,
  output logic m2_int_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m2_int       <= 1'b0;
      ins3_int     <= 1'b0;
      m2_int_valid <= 1'b0;
    end else if (cap) begin
      if (cap_rise) begin
        m2_int       <= m2;
        m2_int_valid <= 1'b1;
      end else begin
        ins3_int     <= m2;
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!m2_int && !ins3_int && !m2_int_valid));
  p_m2int_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(cap && cap_rise) |=> $stable(m2_int));
  p_ins3_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(cap && !cap_rise) |=> $stable(ins3_int));
  p_valid_by_rise_r4: assert property (@(posedge clk) disable iff (rst)
    !(cap && cap_rise) && !m2_int_valid |=> !m2_int_valid);
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    m2_int_valid |=> m2_int_valid);
endmodule

// File: rtl/mode_pin_latch.sv
module mode_pin_latch
  import mpl_pkg::*;
#(
  parameter int CAPTURE_EDGE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_n,
  input  logic       m1,
  input  logic       m2,
  output logic       m2_int,
  output logic       ins3_int,
  output logic       m2_int_valid,
  output logic [1:0] mode
);
  logic  edge_any, edge_rise, cap, cap_rise;
  mode_e mode_w;

  mpl_edge_det u_edge (
    .clk(clk), .rst(rst), .sync_n(sync_n),
    .edge_any(edge_any), .edge_rise(edge_rise)
  );

  mpl_cap_timer #(.CAPTURE_EDGE(CAPTURE_EDGE)) u_timer (
    .clk(clk), .rst(rst), .edge_any(edge_any), .edge_rise(edge_rise),
    .cap(cap), .cap_rise(cap_rise)
  );

  mpl_cfg_regs u_regs (
    .clk(clk), .rst(rst), .cap(cap), .cap_rise(cap_rise), .m2(m2),
    .m2_int(m2_int), .ins3_int(ins3_int), .m2_int_valid(m2_int_valid)
  );

  assign mode_w = mode_e'({m1, m2_int});
  assign mode   = mode_w;

  // the format bit only moves on a capture steered by a rising edge
  p_m2int_needs_cap_r3: assert property (@(posedge clk) disable iff (rst)
    $changed(m2_int) |-> $past(cap && cap_rise));
endmodule

// File: tb/tb_mode_pin_latch.sv
module tb_mode_pin_latch;
  logic clk = 1'b0;
  logic rst, sync_n, m1, m2;
  logic m2_int, ins3_int, m2_int_valid;
  logic [1:0] mode;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mode_pin_latch dut (
    .clk(clk), .rst(rst), .sync_n(sync_n), .m1(m1), .m2(m2),
    .m2_int(m2_int), .ins3_int(ins3_int), .m2_int_valid(m2_int_valid),
    .mode(mode)
  );

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sync_n = 1'b1; m1 = 1'b0; m2 = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // toggle sync at a negedge, present val only around the second edge
  task automatic sync_cap(logic lvl, logic val);
    sync_n = lvl; m2 = ~val;
    @(negedge clk);
    m2 = val;
    @(negedge clk);
    m2 = ~val;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 m2_int", {1'b0, m2_int}, 2'b00);
    check("R1 ins3_int", {1'b0, ins3_int}, 2'b00);
    check("R1 valid", {1'b0, m2_int_valid}, 2'b00);
  endtask

  task automatic t_fall_then_rise();
    sync_cap(1'b0, 1'b1);
    check("R2 ins3_int loaded", {1'b0, ins3_int}, 2'b01);
    check("R2 m2_int unchanged", {1'b0, m2_int}, 2'b00);
    check("R4 valid low after fall capture", {1'b0, m2_int_valid}, 2'b00);
    sync_cap(1'b1, 1'b1);
    check("R3 m2_int loaded", {1'b0, m2_int}, 2'b01);
    check("R3 ins3_int unchanged", {1'b0, ins3_int}, 2'b01);
    check("R4 valid set", {1'b0, m2_int_valid}, 2'b01);
  endtask

  task automatic t_only_second_edge();
    // falling edge, m2=1 only on first edge: nothing loaded yet
    sync_n = 1'b0; m2 = 1'b1;
    @(negedge clk);
    check("R5 no load at first edge", {1'b0, ins3_int}, 2'b01);
    m2 = 1'b0;
    @(negedge clk);
    m2 = 1'b1;
    check("R5 second edge value", {1'b0, ins3_int}, 2'b00);
    repeat (3) @(negedge clk);
    check("R5 later edges ignored", {1'b0, ins3_int}, 2'b00);
    check("R9 valid stays", {1'b0, m2_int_valid}, 2'b01);
    check("R2 m2_int kept", {1'b0, m2_int}, 2'b01);
  endtask

  task automatic t_restart();
    // sync currently low; m2_int=1, ins3_int=0
    sync_n = 1'b1; m2 = 1'b0;
    @(negedge clk);
    sync_n = 1'b0; m2 = 1'b0;
    @(negedge clk);
    m2 = 1'b1;
    @(negedge clk);
    m2 = 1'b0;
    check("R6 dropped rise capture", {1'b0, m2_int}, 2'b01);
    check("R6 newer fall captured", {1'b0, ins3_int}, 2'b01);
    repeat (3) @(negedge clk);
    check("R6 no late capture", {ins3_int, m2_int}, 2'b11);
  endtask

  task automatic t_mode();
    m1 = 1'b0;
    #1 check("R7 mode YCC444", mode, 2'b01);
    @(negedge clk);
    m1 = 1'b1;
    #1 check("R7 mode follows m1", mode, 2'b11);
    sync_n = 1'b1;
    sync_cap(1'b1, 1'b0);
    check("R7 mode 2-port 422", mode, 2'b10);
    m1 = 1'b0;
    #1 check("R7 mode RGB", mode, 2'b00);
    @(negedge clk);
  endtask

  task automatic t_follow(logic inv);
    logic h0, h1, s;
    do_reset();
    h0 = 1'b1; h1 = 1'b1; s = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i % 6 == 3) s = ~s;
      sync_n = s;
      m2 = inv ? ~h1 : h1;
      h1 = h0; h0 = s;
      @(negedge clk);
    end
    if (inv) check("R8 inverted delayed", {m2_int, ins3_int}, 2'b10);
    else     check("R8 direct delayed", {m2_int, ins3_int}, 2'b01);
    check("R8 valid", {1'b0, m2_int_valid}, 2'b01);
  endtask

  initial begin
    rst = 1'b1; sync_n = 1'b1; m1 = 1'b0; m2 = 1'b0;
    t_reset();
    t_fall_then_rise();
    t_only_second_edge();
    t_restart();
    t_mode();
    t_follow(1'b0);
    t_follow(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule